// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Interface

This block connects an 8-bit microprocessor bus to the register space of a core that runs on its own clock. A configuration pin picks the strobe convention. In split-strobe mode the host uses separate read and write strobes. In data-strobe mode it uses one data strobe and a read/not-write line. Every strobe passes through a two-flop synchronizer into the core clock. A write takes effect on the synchronized trailing edge of its strobe. An acknowledge output, `host_ready`, tells the host when read data is valid and when the strobe has been seen released.

Behind the bus sit several parts. There are scratch registers and a control register. There is an interrupt block with status and mask registers. There is also a banked RAM that the host reaches only indirectly. To store a word, the host loads the access data register and then writes a word address into a bank's write-select register. To fetch a word, it writes a word address into the bank's read-select register and later reads the fetched word back from the access data register. Each select write opens a short busy window. Any write that begins inside that window and targets a select register or the access data register is discarded and flagged.

Top module: `hbus_iface`

## Requirements
- R1: With `host_mode`=0, a read is active while `host_cs_n` and `host_rd_n` are both low. A write is active while `host_cs_n` and `host_wr_n` are both low. `host_ds_n` and `host_rnw` have no effect.
- R2: With `host_mode`=1, an access is active while `host_cs_n` and `host_ds_n` are both low. `host_rnw`=1 makes it a read and 0 makes it a write. `host_rd_n` and `host_wr_n` have no effect.
- R3: Strobes are synchronized through two core-clock flops. Address and data are captured when a write is first seen. The register is updated on the synchronized trailing edge, and a later read of that register returns the written value.
- R4: For an indirect store, bank k (0..5) has its write-select register at odd address 0x71+2k. Writing word address w there copies the access data register (0x7F) into word w of bank k. This happens two core cycles after the write commits. Banks are independent.
- R5: For an indirect fetch, bank k has its read-select register at even address 0x70+2k. Writing word address w there loads word w of bank k into the access data register two core cycles after the commit. Select registers read back the last word address written.
- R6: A write to 0x70..0x7B or 0x7F is discarded if its strobe is first seen while an indirect access is pending. The discarded write sets status bit 7.
- R7: `host_ready` is 1 when idle. It goes to 0 at the third clock edge after a strobe becomes active, and read data is valid from then on. It returns to 1 at the third edge after the strobe is released.
- R8: `host_doe` is 1 exactly while a read strobe is active at the pins, and 0 otherwise.
- R9: Bit 0 of the control register at 0x0F sets the read mode. When it is 1 (the reset value), read data is latched when the read is first seen and held for the rest of the strobe. When it is 0, `host_dout` follows `host_addr` for the whole strobe.
- R10: The status register at 0x10 has bits 6:0 set by `evt[6:0]` and bit 7 set by a discarded write (R6). Writing 1 to a status bit clears it, and a setting event wins over a clear in the same cycle. Mask register 0x11 enables a status bit with 1. `irq` is the registered OR of the enabled status bits.
- R11: After reset, `host_ready`=1 and `irq`=0. The control register reads 0x01. The scratch registers 0x00..0x07, status, mask, the select registers and the access data register all read 0.
- R12: Reads from unmapped addresses return 0, and writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_mode | input | 1 | 0: split read/write strobes, 1: data strobe with direction line |
| host_cs_n | input | 1 | Chip select, active low |
| host_rd_n | input | 1 | Read strobe (split mode), active low |
| host_wr_n | input | 1 | Write strobe (split mode), active low |
| host_ds_n | input | 1 | Data strobe (data-strobe mode), active low |
| host_rnw | input | 1 | Direction in data-strobe mode, 1 = read |
| host_addr | input | 8 | Register address |
| host_din | input | 8 | Write data from host |
| host_dout | output | 8 | Read data to host |
| host_doe | output | 1 | Output enable for the external data bus driver |
| host_ready | output | 1 | Acknowledge: low = strobe seen, read data valid |
| evt | input | 7 | Core event pulses that set status bits 6:0 |
| irq | output | 1 | Interrupt request, active high |

## Verification
Some properties are checked by assertions on every cycle:
- the acknowledge falls after every synchronized read start, and
- rises after both strobes are synchronized low;
- latched read data stays steady during a long read;
- the select registers stay frozen while an access is pending;
- an event always leaves its status bit set.

The remaining behaviour can only be shown by the bench's scenarios:
- the decoding of the two strobe styles and the inputs each style ignores;
- the data actually moved through the indirect path, including bank isolation;
- the discard of a colliding write, shown by the access data register keeping its old value;
- the exact edge count to the acknowledge;
- write-one-to-clear and masking on the interrupt line.

// File: rtl/hbi_pkg.sv
// Package: shared constants and types for the host bus interface.
// Assumes an 8-bit address and data bus; the address map lives here so that
// every submodule decodes the same locations.
package hbi_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL     = 8'h0F;
    localparam logic [ADDR_W-1:0] A_STAT     = 8'h10;
    localparam logic [ADDR_W-1:0] A_MASK     = 8'h11;
    localparam logic [ADDR_W-1:0] A_SEL_BASE = 8'h70;
    localparam logic [ADDR_W-1:0] A_ACC      = 8'h7F;

    typedef enum logic {
        BUS_SPLIT   = 1'b0,
        BUS_DSTROBE = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/hbi_strobe_sync.sv
// Module: hbi_strobe_sync
// Decodes the host strobes for either bus style into raw read/write
// requests, synchronizes them into the core clock and produces level and
// edge pulses. Assumes the host holds address/data steady while strobing.
module hbi_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_mode,
    input  logic host_cs_n,
    input  logic host_rd_n,
    input  logic host_wr_n,
    input  logic host_ds_n,
    input  logic host_rnw,
    output logic rd_raw,
    output logic rd_lvl,
    output logic wr_lvl,
    output logic rd_lead,
    output logic wr_lead,
    output logic wr_trail
);
    import hbi_pkg::*;

    bus_mode_e   mode;
    logic        wr_raw;
    logic [STAGES-1:0] rd_pipe, wr_pipe;
    logic        rd_prev, wr_prev;

    assign mode = bus_mode_e'(host_mode);

    // Purpose: map the selected strobe convention onto read/write requests.
    always_comb begin
        if (mode == BUS_DSTROBE) begin
            rd_raw = !host_cs_n && !host_ds_n &&  host_rnw;
            wr_raw = !host_cs_n && !host_ds_n && !host_rnw;
        end else begin
            rd_raw = !host_cs_n && !host_rd_n;
            wr_raw = !host_cs_n && !host_wr_n;
        end
    end

    // Purpose: multi-flop synchronizer plus one history flop for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pipe <= '0;
            wr_pipe <= '0;
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_pipe <= {rd_pipe[STAGES-2:0], rd_raw};
            wr_pipe <= {wr_pipe[STAGES-2:0], wr_raw};
            rd_prev <= rd_pipe[STAGES-1];
            wr_prev <= wr_pipe[STAGES-1];
        end
    end

    assign rd_lvl   = rd_pipe[STAGES-1];
    assign wr_lvl   = wr_pipe[STAGES-1];
    assign rd_lead  = rd_lvl && !rd_prev;
    assign wr_lead  = wr_lvl && !wr_prev;
    assign wr_trail = !wr_lvl && wr_prev;
endmodule

// File: rtl/hbi_ram_seq.sv
// Module: hbi_ram_seq
// Indirect RAM access: per-bank read-select and write-select registers, a
// shared access data register and a countdown that completes each access
// ACC_LAT core cycles after its commit. Writes to guarded addresses whose
// strobe starts during the countdown are dropped and reported.
// Assumes one host: a new write begins only after the previous one ended.
module hbi_ram_seq #(
    parameter int NBANK   = 6,
    parameter int DEPTH   = 16,
    parameter int ACC_LAT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_lead,
    input  logic                        wr_trail,
    input  logic [hbi_pkg::ADDR_W-1:0]  host_addr,
    input  logic [hbi_pkg::ADDR_W-1:0]  cap_addr,
    input  logic [hbi_pkg::DATA_W-1:0]  cap_din,
    output logic [hbi_pkg::DATA_W-1:0]  rdata,
    output logic                        hit,
    output logic                        err_pulse
);
    import hbi_pkg::*;

    localparam int WW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int CW = $clog2(ACC_LAT + 1);
    localparam int MW = $clog2(NBANK * DEPTH);
    localparam logic [ADDR_W-1:0] SEL_END = ADDR_W'(int'(A_SEL_BASE) + 2 * NBANK);

    logic [NBANK-1:0][WW-1:0] rsel_q, wsel_q;
    logic [DATA_W-1:0]        acc_q;
    logic [DATA_W-1:0]        mem_q [NBANK*DEPTH];
    logic [CW-1:0]            cnt_q;
    logic                     pend_wr_q;
    logic [BW-1:0]            pend_bank_q;
    logic [WW-1:0]            pend_word_q;
    logic                     blk_q;
    logic                     busy, commit, fire;
    logic [MW-1:0]            idx;

    function automatic logic is_sel(input logic [ADDR_W-1:0] a);
        return (a >= A_SEL_BASE) && (a < SEL_END);
    endfunction

    function automatic logic [BW-1:0] bank_of(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] off;
        off = a - A_SEL_BASE;
        return BW'(off >> 1);
    endfunction

    assign busy   = (cnt_q != '0);
    assign commit = wr_trail && !blk_q;
    assign fire   = (cnt_q == CW'(1));
    assign idx    = MW'(pend_bank_q) * MW'(DEPTH) + MW'(pend_word_q);
    assign err_pulse = wr_trail && blk_q;

    // Purpose: mark a write as blocked when it starts inside the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= 1'b0;
        end else if (wr_lead) begin
            blk_q <= busy && (is_sel(host_addr) || host_addr == A_ACC);
        end else if (wr_trail) begin
            blk_q <= 1'b0;
        end
    end

    // Purpose: select/data registers, access countdown and fetch completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel_q      <= '0;
            wsel_q      <= '0;
            acc_q       <= '0;
            cnt_q       <= '0;
            pend_wr_q   <= 1'b0;
            pend_bank_q <= '0;
            pend_word_q <= '0;
        end else begin
            if (busy) cnt_q <= cnt_q - 1'b1;
            if (fire && !pend_wr_q) acc_q <= mem_q[idx];
            if (commit) begin
                if (cap_addr == A_ACC) begin
                    acc_q <= cap_din;
                end else if (is_sel(cap_addr)) begin
                    if (cap_addr[0]) wsel_q[bank_of(cap_addr)] <= cap_din[WW-1:0];
                    else             rsel_q[bank_of(cap_addr)] <= cap_din[WW-1:0];
                    pend_wr_q   <= cap_addr[0];
                    pend_bank_q <= bank_of(cap_addr);
                    pend_word_q <= cap_din[WW-1:0];
                    cnt_q       <= CW'(ACC_LAT);
                end
            end
        end
    end

    // Purpose: RAM store at the end of a pending write-select access.
    always_ff @(posedge clk) begin
        if (fire && pend_wr_q) mem_q[idx] <= acc_q;
    end

    // Purpose: read-back of select and access data registers.
    always_comb begin
        hit   = 1'b0;
        rdata = '0;
        if (host_addr == A_ACC) begin
            hit   = 1'b1;
            rdata = acc_q;
        end else if (is_sel(host_addr)) begin
            hit   = 1'b1;
            rdata = host_addr[0] ? DATA_W'(wsel_q[bank_of(host_addr)])
                                 : DATA_W'(rsel_q[bank_of(host_addr)]);
        end
    end

    // R6: select registers cannot change while an access is pending.
    p_sel_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(rsel_q) && $stable(wsel_q)));
endmodule

// File: rtl/hbi_regs.sv
// Module: hbi_regs
// Scratch registers, control register (read mode) and the interrupt
// status/mask pair with registered request output. Writes arrive as a
// commit pulse with captured address and data from the core domain.
module hbi_regs #(
    parameter int NSCR = 8,
    parameter int NEVT = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [hbi_pkg::ADDR_W-1:0] cap_addr,
    input  logic [hbi_pkg::DATA_W-1:0] cap_din,
    input  logic [hbi_pkg::ADDR_W-1:0] host_addr,
    input  logic [NEVT-1:0]            evt,
    input  logic                       err_pulse,
    output logic [hbi_pkg::DATA_W-1:0] rdata,
    output logic                       hit,
    output logic                       sync_rd,
    output logic                       irq
);
    import hbi_pkg::*;

    localparam int SW   = (NSCR > 1) ? $clog2(NSCR) : 1;
    localparam int ST_W = NEVT + 1;

    logic [NSCR-1:0][DATA_W-1:0] scr_q;
    logic                        ctrl_q;
    logic [ST_W-1:0]             st_q, mk_q, clr;
    logic                        irq_q;

    assign clr = (commit && cap_addr == A_STAT) ? cap_din[ST_W-1:0] : '0;

    // Purpose: host-written configuration and scratch storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scr_q  <= '0;
            ctrl_q <= 1'b1;
            mk_q   <= '0;
        end else if (commit) begin
            if (cap_addr < ADDR_W'(NSCR)) scr_q[cap_addr[SW-1:0]] <= cap_din;
            if (cap_addr == A_CTRL) ctrl_q <= cap_din[0];
            if (cap_addr == A_MASK) mk_q   <= cap_din[ST_W-1:0];
        end
    end

    // Purpose: sticky status with write-one-to-clear; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            st_q  <= (st_q & ~clr) | {err_pulse, evt};
            irq_q <= |(st_q & mk_q);
        end
    end

    assign sync_rd = ctrl_q;
    assign irq     = irq_q;

    // Purpose: read-back multiplexer for the registers owned here.
    always_comb begin
        hit   = 1'b1;
        rdata = '0;
        if (host_addr < ADDR_W'(NSCR)) rdata = scr_q[host_addr[SW-1:0]];
        else if (host_addr == A_CTRL)  rdata = DATA_W'(ctrl_q);
        else if (host_addr == A_STAT)  rdata = DATA_W'(st_q);
        else if (host_addr == A_MASK)  rdata = DATA_W'(mk_q);
        else                           hit   = 1'b0;
    end

    // R10: an event always leaves its status bit set on the next cycle.
    p_evt_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((st_q[NEVT-1:0] & $past(evt)) == $past(evt)));
endmodule

// File: rtl/hbus_iface.sv
// Module: hbus_iface (top)
// Host register bus interface with two strobe styles. Captures write
// address/data when a write is first seen, commits on its trailing edge,
// acknowledges through host_ready and drives read data with a separate
// output enable. Assumes the host keeps the strobe asserted until
// host_ready falls and holds address/data steady while strobing.
module hbus_iface #(
    parameter int NSCR        = 8,
    parameter int NEVT        = 7,
    parameter int NBANK       = 6,
    parameter int DEPTH       = 16,
    parameter int ACC_LAT     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_mode,
    input  logic        host_cs_n,
    input  logic        host_rd_n,
    input  logic        host_wr_n,
    input  logic        host_ds_n,
    input  logic        host_rnw,
    input  logic [7:0]  host_addr,
    input  logic [7:0]  host_din,
    output logic [7:0]  host_dout,
    output logic        host_doe,
    output logic        host_ready,
    input  logic [NEVT-1:0] evt,
    output logic        irq
);
    import hbi_pkg::*;

    logic rd_raw, rd_lvl, wr_lvl, rd_lead, wr_lead, wr_trail;
    logic [ADDR_W-1:0] cap_addr_q;
    logic [DATA_W-1:0] cap_din_q, dout_q, live_data;
    logic [DATA_W-1:0] reg_rdata, ram_rdata;
    logic reg_hit, ram_hit, err_pulse, sync_rd, ready_q;

    hbi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_ds_n(host_ds_n), .host_rnw(host_rnw),
        .rd_raw(rd_raw), .rd_lvl(rd_lvl), .wr_lvl(wr_lvl),
        .rd_lead(rd_lead), .wr_lead(wr_lead), .wr_trail(wr_trail)
    );

    hbi_regs #(.NSCR(NSCR), .NEVT(NEVT)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(wr_trail),
        .cap_addr(cap_addr_q), .cap_din(cap_din_q), .host_addr(host_addr),
        .evt(evt), .err_pulse(err_pulse), .rdata(reg_rdata), .hit(reg_hit),
        .sync_rd(sync_rd), .irq(irq)
    );

    hbi_ram_seq #(.NBANK(NBANK), .DEPTH(DEPTH), .ACC_LAT(ACC_LAT)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_lead(wr_lead), .wr_trail(wr_trail),
        .host_addr(host_addr), .cap_addr(cap_addr_q), .cap_din(cap_din_q),
        .rdata(ram_rdata), .hit(ram_hit), .err_pulse(err_pulse)
    );

    // Purpose: combine read sources; unmapped addresses read as zero.
    always_comb begin
        if (reg_hit)      live_data = reg_rdata;
        else if (ram_hit) live_data = ram_rdata;
        else              live_data = '0;
    end

    // Purpose: capture write address/data when a write is first seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr_q <= '0;
            cap_din_q  <= '0;
        end else if (wr_lead) begin
            cap_addr_q <= host_addr;
            cap_din_q  <= host_din;
        end
    end

    // Purpose: latched read data and acknowledge generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            ready_q <= 1'b1;
        end else begin
            if (rd_lead) dout_q <= live_data;
            ready_q <= !(rd_lvl || wr_lvl);
        end
    end

    assign host_ready = ready_q;
    assign host_doe   = rd_raw;
    assign host_dout  = sync_rd ? dout_q : live_data;

    // R7: a newly seen read is acknowledged on the next edge.
    p_ready_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lead |=> !host_ready);

    // R7: acknowledge returns once both strobes are released.
    p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_lvl && !wr_lvl) |=> host_ready);

    // R9: latched read data stays steady through a long read.
    p_hold_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lvl && $past(rd_lvl) && $past(rd_lvl, 2)) |-> $stable(dout_q));
endmodule

// File: tb/sim_hbus_iface.sv
// Directed bench for hbus_iface: one task per scenario, each self-checking.
module sim_hbus_iface;
    localparam int CLK_PER = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_mode = 1'b0;
    logic host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic host_ds_n = 1'b1, host_rnw = 1'b1;
    logic [7:0] host_addr = '0, host_din = '0;
    logic [7:0] host_dout;
    logic host_doe, host_ready, irq;
    logic [6:0] evt = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    hbus_iface u0 (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_ds_n(host_ds_n), .host_rnw(host_rnw), .host_addr(host_addr),
        .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
        .host_ready(host_ready), .evt(evt), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_ready(input logic lvl);
        do @(negedge clk); while (host_ready !== lvl);
    endtask

    task automatic strobe_on(input logic rd);
        host_cs_n = 1'b0;
        if (host_mode) begin host_rnw = rd; host_ds_n = 1'b0; end
        else if (rd) host_rd_n = 1'b0;
        else host_wr_n = 1'b0;
    endtask

    task automatic strobe_off();
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
        host_ds_n = 1'b1; host_rnw = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_din = d;
        strobe_on(1'b0);
        wait_ready(1'b0);
        @(negedge clk);
        strobe_off();
        wait_ready(1'b1);
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        strobe_on(1'b1);
        wait_ready(1'b0);
        chk("R8 doe during read", 8'(host_doe), 8'h01);
        d = host_dout;
        @(negedge clk);
        strobe_off();
        wait_ready(1'b1);
        chk("R8 doe after read", 8'(host_doe), 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R11 ready at reset", 8'(host_ready), 8'h01);
        chk("R11 irq at reset", 8'(irq), 8'h00);
        chk("R8 doe idle", 8'(host_doe), 8'h00);
        bus_read(8'h0F, d); chk("R11 ctrl reset", d, 8'h01);
        bus_read(8'h02, d); chk("R11 scratch reset", d, 8'h00);
        bus_read(8'h7F, d); chk("R11 access reg reset", d, 8'h00);
    endtask

    task automatic t_split();
        logic [7:0] d;
        host_mode = 1'b0;
        bus_write(8'h01, 8'hA5);
        bus_write(8'h02, 8'h3C);
        bus_read(8'h01, d); chk("R1 R3 split write/read", d, 8'hA5);
        bus_read(8'h02, d); chk("R1 R3 second scratch", d, 8'h3C);
        // R1: data strobe lines are ignored in split mode
        @(negedge clk); host_addr = 8'h01; host_din = 8'h00;
        host_cs_n = 1'b0; host_ds_n = 1'b0; host_rnw = 1'b0;
        repeat (6) @(negedge clk);
        strobe_off(); repeat (6) @(negedge clk);
        bus_read(8'h01, d); chk("R1 ds ignored in split mode", d, 8'hA5);
    endtask

    task automatic t_dstrobe();
        logic [7:0] d;
        host_mode = 1'b1;
        bus_write(8'h03, 8'h5A);
        bus_read(8'h03, d); chk("R2 data-strobe write/read", d, 8'h5A);
        // R2: split strobes ignored in data-strobe mode
        @(negedge clk); host_addr = 8'h03; host_din = 8'hFF;
        host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (6) @(negedge clk);
        strobe_off(); repeat (6) @(negedge clk);
        bus_read(8'h03, d); chk("R2 wr_n ignored in data-strobe mode", d, 8'h5A);
        host_mode = 1'b0;
    endtask

    task automatic t_ready_timing();
        @(negedge clk); host_addr = 8'h01; strobe_on(1'b1);
        repeat (2) @(negedge clk);
        chk("R7 ready still high at edge 2", 8'(host_ready), 8'h01);
        @(negedge clk);
        chk("R7 ready low at edge 3", 8'(host_ready), 8'h00);
        strobe_off();
        repeat (2) @(negedge clk);
        chk("R7 ready still low at edge 2 after release", 8'(host_ready), 8'h00);
        @(negedge clk);
        chk("R7 ready high at edge 3 after release", 8'(host_ready), 8'h01);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        bus_write(8'h40, 8'hFF);
        bus_read(8'h40, d); chk("R12 unmapped reads zero", d, 8'h00);
        bus_read(8'h01, d); chk("R12 unmapped write harmless", d, 8'hA5);
    endtask

    task automatic t_indirect();
        logic [7:0] d;
        bus_write(8'h7F, 8'h11); bus_write(8'h75, 8'h05);
        bus_write(8'h7F, 8'h22); bus_write(8'h75, 8'h06);
        bus_write(8'h7F, 8'h99); bus_write(8'h71, 8'h05);
        bus_write(8'h74, 8'h05);
        bus_read(8'h7F, d); chk("R4 R5 bank2 word5", d, 8'h11);
        bus_write(8'h74, 8'h06);
        bus_read(8'h7F, d); chk("R4 R5 bank2 word6", d, 8'h22);
        bus_write(8'h70, 8'h05);
        bus_read(8'h7F, d); chk("R4 bank0 word5 separate", d, 8'h99);
        bus_read(8'h75, d); chk("R5 write-select read-back", d, 8'h06);
        bus_read(8'h74, d); chk("R5 read-select read-back", d, 8'h06);
    endtask

    task automatic t_guard();
        logic [7:0] d;
        bus_write(8'h7F, 8'h55);
        @(negedge clk); host_addr = 8'h71; host_din = 8'h03; strobe_on(1'b0);
        wait_ready(1'b0);
        @(negedge clk); strobe_off();
        @(negedge clk); host_addr = 8'h7F; host_din = 8'hAA; strobe_on(1'b0);
        repeat (4) @(negedge clk);
        strobe_off();
        wait_ready(1'b1);
        repeat (4) @(negedge clk);
        bus_read(8'h7F, d); chk("R6 colliding write dropped", d, 8'h55);
        bus_read(8'h10, d); chk("R6 R10 collision status bit7", d & 8'h80, 8'h80);
        bus_write(8'h70, 8'h03);
        bus_read(8'h7F, d); chk("R4 store before collision done", d, 8'h55);
        bus_write(8'h10, 8'h80);
        bus_read(8'h10, d); chk("R10 collision bit cleared", d, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        bus_write(8'h11, 8'h00);
        @(negedge clk); evt = 7'h08; @(negedge clk); evt = 7'h00;
        repeat (3) @(negedge clk);
        chk("R10 masked event no irq", 8'(irq), 8'h00);
        bus_read(8'h10, d); chk("R10 event sets status", d, 8'h08);
        bus_write(8'h11, 8'h08);
        chk("R10 enabled irq", 8'(irq), 8'h01);
        bus_write(8'h10, 8'h08);
        chk("R10 w1c drops irq", 8'(irq), 8'h00);
        bus_read(8'h10, d); chk("R10 status cleared", d, 8'h00);
    endtask

    task automatic t_readmode();
        logic [7:0] d;
        bus_write(8'h0F, 8'h00);
        @(negedge clk); host_addr = 8'h01; strobe_on(1'b1);
        wait_ready(1'b0);
        chk("R9 live first", host_dout, 8'hA5);
        host_addr = 8'h02; @(negedge clk);
        chk("R9 live follows address", host_dout, 8'h3C);
        strobe_off(); wait_ready(1'b1);
        bus_write(8'h0F, 8'h01);
        bus_read(8'h0F, d); chk("R9 ctrl read-back", d, 8'h01);
        @(negedge clk); host_addr = 8'h01; strobe_on(1'b1);
        wait_ready(1'b0);
        host_addr = 8'h02; repeat (2) @(negedge clk);
        chk("R9 latched data held", host_dout, 8'hA5);
        strobe_off(); wait_ready(1'b1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_split();
        t_dstrobe();
        t_ready_timing();
        t_unmapped();
        t_indirect();
        t_guard();
        t_irq();
        t_readmode();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule